// File: doc/BRIEF.md
# Butterfly Destination-Tag Switching Fabric

This block is a multistage interconnect. It has 2^K input ports and 2^K output ports, and between them sit K ranks of two-by-two switch nodes. A valid packet arrives on an input port with a K-bit destination column. Each rank reads one bit of that address, starting at the most significant bit, and steers the packet to one side of its node. When the last rank has been crossed, every bit of the packet's column agrees with its address, so the packet leaves on the output port the address names. No rank needs a lookup table.

The partner rule sets both the wiring and the steering. At rank s the node pairs column j with j XOR 2^(K-s). A packet moves to whichever column of the pair has address bit K-s equal to that bit of its own column. Each rank ends in one pipeline register, so a full wave of packets crosses the fabric in exactly K cycles, and a new wave can enter on every cycle.

Two valid packets in one node can ask for the same side. The packet on the lower-numbered column then wins and the other is dropped. The fabric records the drop against the input port where the lost packet entered. That blocked flag comes out in the same cycle as the rest of the packet's wave.

Top module: `butterfly_fabric`

## Requirements
- R1: With the default K=3 there are 8 input and 8 output ports. While reset is held, and in the cycle after reset is released, all out_vld bits and all out_blocked bits are 0.
- R2: A wave driven on the inputs before clock edge E shows up on the outputs after edge E+K-1, which is exactly K edges. Before that, the outputs show nothing from the wave.
- R3: A valid packet that meets no conflict leaves on the output port whose index equals in_dst. Its data is unchanged. Port p's fields are in_dst[p*K +: K], in_data[p*W +: W] and out_data[p*W +: W].
- R4: Rank s, for s from 1 to K, pairs column j with j XOR 2^(K-s). It moves each packet to the column of the pair whose bit K-s equals destination bit K-s. A single packet from input 2 addressed to 5 therefore reaches output 5.
- R5: When two valid packets in one node need the same side, the packet on the lower-numbered column goes on and the other is dropped. No packet is ever duplicated.
- R6: Each dropped packet sets out_blocked[p] for exactly one cycle, where p is the input port on which it entered. That cycle is the one in which its wave reaches the outputs. A port never shows delivered and blocked in the same wave.
- R7: An input with in_vld low produces no output and no blocked flag, whatever its address and data.
- R8: Waves on consecutive cycles do not disturb each other. Each one emerges K cycles after it entered.
- R9: Any permutation of the form dst = src XOR c is conflict-free, and every packet in it is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | N | Valid flag per input port (N = 2^K) |
| in_dst | input | N*K | Destination column per input port |
| in_data | input | N*W | Data per input port |
| out_vld | output | N | Valid flag per output port |
| out_data | output | N*W | Data per output port |
| out_blocked | output | N | Per-input-port flag: this port's packet was dropped in the wave now at the outputs |

## Verification
On every cycle, the assertions check three things. Each rank places a valid packet only in a column whose steering bit matches the packet's address. Packets that enter a rank equal packets that leave it plus packets dropped in it. The blocked count grows by exactly the number of drops. At the outputs they also check that a packet's address equals its output column and that a delivered source is never flagged as blocked. Some behaviour can only be shown by the bench scenarios, which compare against values worked out by hand: that the lower column wins a conflict, which source port is blocked, the exact K-cycle latency, and that data arrives intact through full permutations and back-to-back waves.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    localparam int unsigned DEF_ADDR_W = 3;
    localparam int unsigned DEF_DATA_W = 16;

    // Column of the lower member of node p when the pair differs in bit bp.
    function automatic int unsigned lo_col(input int unsigned p, input int unsigned bp);
        int unsigned low_mask;
        low_mask = (32'd1 << bp) - 32'd1;
        return ((p >> bp) << (bp + 1)) | (p & low_mask);
    endfunction

    // Packed packet width: valid, source, destination, data.
    function automatic int unsigned pkt_width(input int unsigned aw, input int unsigned dw);
        return dw + 2 * aw + 1;
    endfunction

endpackage

// File: rtl/bfly_node.sv
module bfly_node #(
    parameter int unsigned ADDR_W = bfly_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = bfly_pkg::DEF_DATA_W,
    parameter int unsigned BP     = 0
) (
    input  logic [bfly_pkg::pkt_width(ADDR_W, DATA_W)-1:0] lo_i,
    input  logic [bfly_pkg::pkt_width(ADDR_W, DATA_W)-1:0] hi_i,
    output logic [bfly_pkg::pkt_width(ADDR_W, DATA_W)-1:0] lo_o,
    output logic [bfly_pkg::pkt_width(ADDR_W, DATA_W)-1:0] hi_o,
    output logic                                           drop_o
);
    localparam int unsigned PW    = bfly_pkg::pkt_width(ADDR_W, DATA_W);
    localparam int unsigned V_POS = PW - 1;
    localparam int unsigned B_POS = DATA_W + BP;

    logic lo_v, hi_v, lo_b, hi_b;

    always_comb begin
        lo_v = lo_i[V_POS];
        hi_v = hi_i[V_POS];
        lo_b = lo_i[B_POS];
        hi_b = hi_i[B_POS];

        // Lower output: lower input has priority.
        if (lo_v && !lo_b)      lo_o = lo_i;
        else if (hi_v && !hi_b) lo_o = hi_i;
        else                    lo_o = '0;

        // Upper output: lower input has priority.
        if (lo_v && lo_b)       hi_o = lo_i;
        else if (hi_v && hi_b)  hi_o = hi_i;
        else                    hi_o = '0;

        drop_o = lo_v && hi_v && (lo_b == hi_b);
    end

endmodule

// File: rtl/bfly_stage.sv
module bfly_stage #(
    parameter int unsigned ADDR_W = bfly_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = bfly_pkg::DEF_DATA_W,
    parameter int unsigned STAGE  = 1
) (
    input  logic                                                         clk,
    input  logic                                                         rst_n,
    input  logic [(1<<ADDR_W)-1:0][bfly_pkg::pkt_width(ADDR_W, DATA_W)-1:0] i_pkt,
    input  logic [(1<<ADDR_W)-1:0]                                       i_blk,
    output logic [(1<<ADDR_W)-1:0][bfly_pkg::pkt_width(ADDR_W, DATA_W)-1:0] o_pkt,
    output logic [(1<<ADDR_W)-1:0]                                       o_blk
);
    localparam int unsigned N     = 1 << ADDR_W;
    localparam int unsigned HALF  = N / 2;
    localparam int unsigned PW    = bfly_pkg::pkt_width(ADDR_W, DATA_W);
    localparam int unsigned BP    = ADDR_W - STAGE;
    localparam int unsigned V_POS = PW - 1;
    localparam int unsigned S_POS = DATA_W + ADDR_W;

    typedef struct packed {
        logic [N-1:0][PW-1:0] pkt;
        logic [N-1:0]         blk;
    } stage_t;

    stage_t st_d, st_q;

    logic [HALF-1:0][PW-1:0] nlo, nhi;
    logic [HALF-1:0]         ndrop;
    logic [N-1:0]            iv, ov;

    genvar p;
    generate
        for (p = 0; p < HALF; p++) begin : g_node
            localparam int unsigned LO = bfly_pkg::lo_col(p, BP);
            localparam int unsigned HI = LO + (1 << BP);
            bfly_node #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BP(BP)) u_node (
                .lo_i  (i_pkt[LO]),
                .hi_i  (i_pkt[HI]),
                .lo_o  (nlo[p]),
                .hi_o  (nhi[p]),
                .drop_o(ndrop[p])
            );
        end
    endgenerate

    always_comb begin
        st_d.pkt = '0;
        st_d.blk = i_blk;
        for (int unsigned q = 0; q < HALF; q++) begin
            int unsigned lc;
            int unsigned hc;
            logic [ADDR_W-1:0] lost_src;
            lc = bfly_pkg::lo_col(q, BP);
            hc = lc + (32'd1 << BP);
            st_d.pkt[lc] = nlo[q];
            st_d.pkt[hc] = nhi[q];
            lost_src = i_pkt[hc][S_POS +: ADDR_W];
            if (ndrop[q]) st_d.blk[lost_src] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_pkt = st_q.pkt;
    assign o_blk = st_q.blk;

    always_comb begin
        for (int unsigned c = 0; c < N; c++) begin
            iv[c] = i_pkt[c][V_POS];
            ov[c] = st_q.pkt[c][V_POS];
        end
    end

    // Packets leaving this rank equal packets entering minus those dropped.
    p_conserve_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(ov) + $countones($past(ndrop)) == $countones($past(iv))));

    // Each drop adds exactly one new blocked source.
    p_blk_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(st_q.blk) == $countones($past(i_blk)) + $countones($past(ndrop))));

    genvar c;
    generate
        for (c = 0; c < N; c++) begin : g_chk
            localparam logic COLBIT = 1'((c >> BP) & 1);
            // A packet sits only in the column whose steering bit matches its address.
            p_route_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.pkt[c][V_POS] |-> (st_q.pkt[c][DATA_W + BP] == COLBIT));
        end
    endgenerate

endmodule

// File: rtl/butterfly_fabric.sv
module butterfly_fabric #(
    parameter int unsigned ADDR_W = bfly_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = bfly_pkg::DEF_DATA_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [(1<<ADDR_W)-1:0]         in_vld,
    input  logic [(1<<ADDR_W)*ADDR_W-1:0]  in_dst,
    input  logic [(1<<ADDR_W)*DATA_W-1:0]  in_data,
    output logic [(1<<ADDR_W)-1:0]         out_vld,
    output logic [(1<<ADDR_W)*DATA_W-1:0]  out_data,
    output logic [(1<<ADDR_W)-1:0]         out_blocked
);
    localparam int unsigned N     = 1 << ADDR_W;
    localparam int unsigned PW    = bfly_pkg::pkt_width(ADDR_W, DATA_W);
    localparam int unsigned V_POS = PW - 1;
    localparam int unsigned D_POS = DATA_W;
    localparam int unsigned S_POS = DATA_W + ADDR_W;

    logic [N-1:0][PW-1:0] rank_pkt [ADDR_W+1];
    logic [N-1:0]         rank_blk [ADDR_W+1];

    genvar c, s;
    generate
        for (c = 0; c < N; c++) begin : g_in
            assign rank_pkt[0][c] = {in_vld[c], ADDR_W'(c),
                                     in_dst[c*ADDR_W +: ADDR_W],
                                     in_data[c*DATA_W +: DATA_W]};
        end
    endgenerate
    assign rank_blk[0] = '0;

    generate
        for (s = 1; s <= ADDR_W; s++) begin : g_rank
            bfly_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGE(s)) u_stage (
                .clk  (clk),
                .rst_n(rst_n),
                .i_pkt(rank_pkt[s-1]),
                .i_blk(rank_blk[s-1]),
                .o_pkt(rank_pkt[s]),
                .o_blk(rank_blk[s])
            );
        end
    endgenerate

    generate
        for (c = 0; c < N; c++) begin : g_out
            assign out_vld[c]                = rank_pkt[ADDR_W][c][V_POS];
            assign out_data[c*DATA_W +: DATA_W] = rank_pkt[ADDR_W][c][DATA_W-1:0];

            // A delivered packet's address names its output column.
            p_dst_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld[c] |-> (rank_pkt[ADDR_W][c][D_POS +: ADDR_W] == ADDR_W'(c)));

            // A source is never both delivered and blocked in the same wave.
            p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld[c] |-> !out_blocked[rank_pkt[ADDR_W][c][S_POS +: ADDR_W]]);
        end
    endgenerate

    assign out_blocked = rank_blk[ADDR_W];

endmodule

// File: tb/butterfly_fabric_test.sv
module butterfly_fabric_test;
    localparam int unsigned K = 3;
    localparam int unsigned W = 16;
    localparam int unsigned N = 1 << K;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N-1:0]       in_vld = '0;
    logic [N*K-1:0]     in_dst = '0;
    logic [N*W-1:0]     in_data = '0;
    logic [N-1:0]       out_vld;
    logic [N*W-1:0]     out_data;
    logic [N-1:0]       out_blocked;

    int checks = 0;
    int fails = 0;

    logic [N-1:0] exp_vld;
    logic [N-1:0] exp_blk;
    logic [W-1:0] exp_data [N];
    logic [K-1:0] dst_tab [N];

    always #5 clk = ~clk; // 10 ns period, 100 MHz

    butterfly_fabric #(.ADDR_W(K), .DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dst(in_dst), .in_data(in_data),
        .out_vld(out_vld), .out_data(out_data), .out_blocked(out_blocked)
    );

    function automatic logic [W-1:0] mk_data(input int src, input int tag);
        return W'(16'h5A00 + tag * 16 + src);
    endfunction

    task automatic check_out(input string req, input string name);
        checks++;
        if (out_vld !== exp_vld) begin
            fails++;
            $display("FAIL %s %s out_vld actual=%b expected=%b", req, name, out_vld, exp_vld);
        end
        checks++;
        if (out_blocked !== exp_blk) begin
            fails++;
            $display("FAIL %s %s out_blocked actual=%b expected=%b", req, name, out_blocked, exp_blk);
        end
        for (int c = 0; c < N; c++) begin
            if (exp_vld[c]) begin
                checks++;
                if (out_data[c*W +: W] !== exp_data[c]) begin
                    fails++;
                    $display("FAIL %s %s data port %0d actual=%h expected=%h",
                             req, name, c, out_data[c*W +: W], exp_data[c]);
                end
            end
        end
    endtask

    task automatic check_idle(input string req, input string name);
        checks++;
        if (out_vld !== '0 || out_blocked !== '0) begin
            fails++;
            $display("FAIL %s %s early output actual vld=%b blk=%b expected 0/0",
                     req, name, out_vld, out_blocked);
        end
    endtask

    // Drive from dst_tab on ports in v, with tag for data.
    task automatic drive(input logic [N-1:0] v, input int tag);
        in_vld = v;
        for (int c = 0; c < N; c++) begin
            in_dst[c*K +: K]  = dst_tab[c];
            in_data[c*W +: W] = mk_data(c, tag);
        end
    endtask

    task automatic clear_exp();
        exp_vld = '0;
        exp_blk = '0;
        for (int c = 0; c < N; c++) exp_data[c] = '0;
    endtask

    // Conflict-free expectation from dst_tab.
    task automatic expect_perm(input logic [N-1:0] v, input int tag);
        clear_exp();
        for (int c = 0; c < N; c++) begin
            if (v[c]) begin
                exp_vld[dst_tab[c]]  = 1'b1;
                exp_data[dst_tab[c]] = mk_data(c, tag);
            end
        end
    endtask

    // One wave: drive, check stays idle until K edges, then check.
    task automatic run_wave(input logic [N-1:0] v, input int tag, input string req, input string name);
        @(negedge clk);
        drive(v, tag);
        for (int i = 1; i <= int'(K); i++) begin
            @(negedge clk);
            if (i == 1) in_vld = '0;
            if (i == int'(K) - 1) check_idle("R2", name);
        end
        check_out(req, name);
        @(negedge clk);
        clear_exp();
        check_out(req, {name, " after"});
    endtask

    task automatic t_reset();
        clear_exp();
        check_out("R1", "during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", "after release");
    endtask

    task automatic t_xor_perms();
        for (int x = 0; x < int'(N); x++) begin
            for (int c = 0; c < N; c++) dst_tab[c] = K'(c ^ x);
            expect_perm('1, x);
            run_wave('1, x, (x == 0) ? "R3" : "R9", $sformatf("xor perm %0d", x));
        end
    endtask

    task automatic t_single_2_to_5();
        for (int c = 0; c < N; c++) dst_tab[c] = '0;
        dst_tab[2] = 3'd5;
        expect_perm(8'b0000_0100, 20);
        run_wave(8'b0000_0100, 20, "R4", "single 2->5");
    endtask

    task automatic t_invalid_ignored();
        for (int c = 0; c < N; c++) dst_tab[c] = K'(N - 1 - c);
        clear_exp();
        run_wave('0, 21, "R7", "all invalid");
    endtask

    task automatic t_conflict_first_rank();
        for (int c = 0; c < N; c++) dst_tab[c] = '0;
        clear_exp();
        exp_vld[0]  = 1'b1;
        exp_data[0] = mk_data(0, 22);
        exp_blk[4]  = 1'b1;
        run_wave(8'b0001_0001, 22, "R5", "ports 0,4 -> 0");
    endtask

    task automatic t_conflict_last_rank();
        for (int c = 0; c < N; c++) dst_tab[c] = 3'd3;
        clear_exp();
        exp_vld[3]  = 1'b1;
        exp_data[3] = mk_data(0, 23);
        exp_blk[1]  = 1'b1;
        run_wave(8'b0000_0011, 23, "R6", "ports 0,1 -> 3");
    endtask

    task automatic t_all_to_zero();
        for (int c = 0; c < N; c++) dst_tab[c] = '0;
        clear_exp();
        exp_vld[0]  = 1'b1;
        exp_data[0] = mk_data(0, 24);
        exp_blk     = 8'hFE;
        run_wave('1, 24, "R5", "all -> 0");
    endtask

    task automatic t_back_to_back();
        logic [K-1:0] tab_b [N];
        for (int c = 0; c < N; c++) begin
            dst_tab[c] = K'(c ^ 3);
            tab_b[c]   = K'(c ^ 6);
        end
        @(negedge clk);
        drive('1, 25);
        @(negedge clk);
        for (int c = 0; c < N; c++) dst_tab[c] = tab_b[c];
        drive(8'b1010_1010, 26);
        @(negedge clk);
        in_vld = '0;
        for (int i = 3; i <= int'(K); i++) @(negedge clk);
        for (int c = 0; c < N; c++) dst_tab[c] = K'(c ^ 3);
        expect_perm('1, 25);
        check_out("R8", "wave A");
        @(negedge clk);
        for (int c = 0; c < N; c++) dst_tab[c] = tab_b[c];
        expect_perm(8'b1010_1010, 26);
        check_out("R8", "wave B");
        @(negedge clk);
        clear_exp();
        check_out("R8", "after waves");
    endtask

    initial begin
        t_reset();
        t_xor_perms();
        t_single_2_to_5();
        t_invalid_ignored();
        t_conflict_first_rank();
        t_conflict_last_rank();
        t_all_to_zero();
        t_back_to_back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule